// File: doc/BRIEF.md
# Sector Erase Window Controller

This block is the erase front end of a flash-style memory array. It takes already decoded commands and builds an erase batch from them. A sector erase command opens an acceptance window. Each further sector erase command that arrives while the window is open adds its sector to the batch and starts the full window again. When the window runs out, the block starts the erase for every selected sector. A chip erase skips the window and selects every sector at once.

A pulse counter stands in for the real erase algorithm. Each selected sector needs a set number of pulses. If the running count goes past a limit, the operation stops and is reported as failed.

Software polls a status byte to follow progress:
- Bit 7 reads 1 when the block is idle or suspended.
- Bit 6 inverts on each status read while work is pending.
- Bit 5 flags a failure.
- Bit 3 reads 1 once the window has closed and the erase is under way.

Top module: `sector_erase_ctl`

## Requirements
- R1: After reset the status byte reads 0x80, the sector mask is all zero and erase_active is 0.
- R2: A sector erase command (cmd_code 1) in the idle state sets that sector's mask bit and opens a window of CLK_MHZ*WINDOW_US cycles. For those cycles status bits 7 and 3 read 0. On the cycle after the last window cycle, bit 3 reads 1 and erase_active is 1.
- R3: A sector erase command received while the window is open ORs its sector into the mask and reloads the full window length.
- R4: A chip erase command (cmd_code 2) from idle sets every mask bit. On the next cycle the erase starts, with erase_active 1 and status bit 3 set, and no window is used.
- R5: While the erase runs, only erase suspend (cmd_code 3) has an effect; every other command, including reset, is ignored. Suspend clears erase_active and shows bits 7 and 3 both set (0x88 with bit 6 clear). Resume (cmd_code 4) continues the erase without losing the pulses already counted.
- R6: The erase needs PULSES_PER_SECTOR times the number of selected sectors cycles of activity. After that the block returns to idle, with the status at 0x80 plus bit 6 and the mask cleared.
- R7: The erase fails when the pulse count would go past PULSE_LIMIT before completion, or at once when force_limit is high during the erase. On failure, status bit 5 is set, bits 3 and 7 read 1 and 0, and erase_active drops. A batch that needs exactly PULSE_LIMIT pulses completes normally.
- R8: After a failure, only reset (cmd_code 5) returns the block to idle, clearing status bit 5 and the mask. All other commands are ignored.
- R9: Status bit 6 inverts after each status_rd pulse while the window is open, the erase runs, or a failure is pending. It holds its value when the block is idle or suspended.
- R10: While the window is open, erase suspend is ignored. Any other command except sector erase (cmd_code 0, 2, 4, 5) abandons the batch, returning the block to idle with the mask cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_code | input | 3 | 0 other, 1 sector erase, 2 chip erase, 3 suspend, 4 resume, 5 reset |
| cmd_sector | input | SEC_W | Sector number for a sector erase |
| status_rd | input | 1 | Status byte is being read this cycle |
| force_limit | input | 1 | Test input: treat the pulse limit as exceeded |
| status | output | 8 | Status byte (bits 7, 6, 5, 3 used) |
| sector_mask | output | NUM_SECTORS | Sectors selected for the current batch |
| erase_active | output | 1 | The erase pulse engine is running |

## Verification
The checker watches several rules on every cycle:
- Status bit 3 is set whenever the erase runs.
- Only reset clears a pending failure.
- A chip erase from idle starts the erase on the next cycle.
- The mask is unchanged by commands issued during an erase.
- Bit 6 flips on every read while work is pending and holds while the block is idle or suspended.

The exact length of the window, its restart by a later sector command, the pulse count at which the erase completes or fails, and the resume with preserved progress all depend on counts spread over many cycles. Only the bench's timed scenarios can show these.

// File: rtl/sew_pkg.sv
// Package: shared command and state encodings for the sector erase controller.
// Assumes the command decoder upstream produces the 3-bit codes below.
package sew_pkg;

    typedef enum logic [2:0] {
        CMD_OTHER        = 3'd0,
        CMD_SECTOR_ERASE = 3'd1,
        CMD_CHIP_ERASE   = 3'd2,
        CMD_SUSPEND      = 3'd3,
        CMD_RESUME       = 3'd4,
        CMD_RESET        = 3'd5
    } sew_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WINDOW  = 3'd1,
        ST_ERASE   = 3'd2,
        ST_SUSPEND = 3'd3,
        ST_FAIL    = 3'd4
    } sew_state_e;

    localparam int STS_POLL   = 7;
    localparam int STS_TOGGLE = 6;
    localparam int STS_LIMIT  = 5;
    localparam int STS_TIMER  = 3;

endpackage

// File: rtl/sew_window_timer.sv
// Module: acceptance window down-counter.
// A load pulse (re)starts the window at its full length. While run is high the
// count decrements; expired is high in the last window cycle when no reload is
// requested. Assumes WINDOW_CYCLES >= 1.
module sew_window_timer #(
    parameter int WINDOW_CYCLES = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(WINDOW_CYCLES + 1);

    logic [TW-1:0] cnt_q;

    // Count the remaining window cycles; a reload always wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= TW'(WINDOW_CYCLES - 1);
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Flag the final cycle of an open window.
    always_comb begin
        expired = run && !load && (cnt_q == '0);
    end

endmodule

// File: rtl/sew_pulse_engine.sv
// Module: stand-in for the erase algorithm.
// Counts one pulse per running cycle. The required total is PULSES_PER_SECTOR
// times the number of mask bits set. done rises in the cycle that issues the
// last required pulse; over rises instead when the next pulse would exceed
// PULSE_LIMIT, or at once when force_over is high. Assumes the mask is stable
// while run is high.
module sew_pulse_engine #(
    parameter int NUM_SECTORS       = 16,
    parameter int PULSES_PER_SECTOR = 256,
    parameter int PULSE_LIMIT       = 4096
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   run,
    input  logic                   force_over,
    input  logic [NUM_SECTORS-1:0] mask,
    output logic                   done,
    output logic                   over
);
    localparam int TOTAL_MAX = NUM_SECTORS * PULSES_PER_SECTOR;
    localparam int CNT_TOP   = ((TOTAL_MAX > PULSE_LIMIT) ? TOTAL_MAX : PULSE_LIMIT) + 1;
    localparam int CW        = $clog2(CNT_TOP + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] need;

    // Sum the pulse budget of every selected sector.
    always_comb begin
        need = '0;
        for (int i = 0; i < NUM_SECTORS; i++) begin
            if (mask[i]) begin
                need = need + CW'(PULSES_PER_SECTOR);
            end
        end
    end

    // Decide completion before failure for the pulse issued this cycle.
    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        done    = run && (cnt_inc >= need);
        over    = run && !done && (force_over || (cnt_inc > CW'(PULSE_LIMIT)));
    end

    // Accumulate issued pulses; held while not running so a resume continues.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/sew_status_gen.sv
// Module: status byte formatter with the read-toggled bit.
// Bit 7 high when idle or suspended, bit 6 toggles per read while work is
// pending, bit 5 marks failure, bit 3 marks that the window has closed.
// Assumes status_rd is a single-cycle strobe per read.
module sew_status_gen (
    input  logic                clk,
    input  logic                rst_n,
    input  sew_pkg::sew_state_e state,
    input  logic                status_rd,
    output logic [7:0]          status
);
    import sew_pkg::*;

    logic tog_q;
    logic pending;

    // Work is pending in the window, during erase, and while a failure stands.
    always_comb begin
        pending = (state == ST_WINDOW) || (state == ST_ERASE) || (state == ST_FAIL);
    end

    // Invert the toggle bit on every read taken while work is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (pending && status_rd) begin
            tog_q <= ~tog_q;
        end
    end

    // Assemble the status byte from the current state.
    always_comb begin
        status             = 8'h00;
        status[STS_POLL]   = (state == ST_IDLE) || (state == ST_SUSPEND);
        status[STS_TOGGLE] = tog_q;
        status[STS_LIMIT]  = (state == ST_FAIL);
        status[STS_TIMER]  = (state == ST_ERASE) || (state == ST_SUSPEND) || (state == ST_FAIL);
    end

endmodule

// File: rtl/sector_erase_ctl.sv
// Module: sector erase batch controller (top).
// Collects sector erase commands inside a restartable acceptance window, runs
// the batch through the pulse engine, supports suspend/resume, and latches a
// failure until reset. Assumes commands arrive already decoded, one per cycle.
module sector_erase_ctl #(
    parameter int CLK_MHZ           = 250,
    parameter int WINDOW_US         = 50,
    parameter int NUM_SECTORS       = 16,
    parameter int PULSES_PER_SECTOR = 256,
    parameter int PULSE_LIMIT       = 4096,
    localparam int SEC_W            = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [2:0]             cmd_code,
    input  logic [SEC_W-1:0]       cmd_sector,
    input  logic                   status_rd,
    input  logic                   force_limit,
    output logic [7:0]             status,
    output logic [NUM_SECTORS-1:0] sector_mask,
    output logic                   erase_active
);
    import sew_pkg::*;

    localparam int WINDOW_CYCLES = CLK_MHZ * WINDOW_US;

    sew_state_e             state_q, state_d;
    logic [NUM_SECTORS-1:0] mask_q, mask_d;
    logic [NUM_SECTORS-1:0] sel;
    sew_cmd_e               cmd;
    logic                   win_load, win_expired;
    logic                   eng_clear, eng_done, eng_over;

    // Decode the sector number into a one-hot select; out-of-range selects none.
    always_comb begin
        for (int i = 0; i < NUM_SECTORS; i++) begin
            sel[i] = (cmd_sector == SEC_W'(i));
        end
    end

    // Next-state and mask decision for every state and command.
    always_comb begin
        cmd       = sew_cmd_e'(cmd_code);
        state_d   = state_q;
        mask_d    = mask_q;
        win_load  = 1'b0;
        eng_clear = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (cmd)
                        CMD_SECTOR_ERASE: begin
                            mask_d    = sel;
                            state_d   = ST_WINDOW;
                            win_load  = 1'b1;
                            eng_clear = 1'b1;
                        end
                        CMD_CHIP_ERASE: begin
                            mask_d    = '1;
                            state_d   = ST_ERASE;
                            eng_clear = 1'b1;
                        end
                        CMD_RESET: mask_d = '0;
                        default: ;
                    endcase
                end
            end
            ST_WINDOW: begin
                if (cmd_valid) begin
                    case (cmd)
                        CMD_SECTOR_ERASE: begin
                            mask_d   = mask_q | sel;
                            win_load = 1'b1;
                        end
                        CMD_SUSPEND: ;
                        default: begin
                            mask_d  = '0;
                            state_d = ST_IDLE;
                        end
                    endcase
                end else if (win_expired) begin
                    state_d = ST_ERASE;
                end
            end
            ST_ERASE: begin
                if (eng_done) begin
                    mask_d  = '0;
                    state_d = ST_IDLE;
                end else if (eng_over) begin
                    state_d = ST_FAIL;
                end else if (cmd_valid && (cmd == CMD_SUSPEND)) begin
                    state_d = ST_SUSPEND;
                end
            end
            ST_SUSPEND: begin
                if (cmd_valid && (cmd == CMD_RESUME)) begin
                    state_d = ST_ERASE;
                end
            end
            ST_FAIL: begin
                if (cmd_valid && (cmd == CMD_RESET)) begin
                    mask_d  = '0;
                    state_d = ST_IDLE;
                end
            end
            default: begin
                mask_d  = '0;
                state_d = ST_IDLE;
            end
        endcase
    end

    // Register the controller state and the sector selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
        end
    end

    sew_window_timer #(
        .WINDOW_CYCLES(WINDOW_CYCLES)
    ) win_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (win_load),
        .run    (state_q == ST_WINDOW),
        .expired(win_expired)
    );

    sew_pulse_engine #(
        .NUM_SECTORS      (NUM_SECTORS),
        .PULSES_PER_SECTOR(PULSES_PER_SECTOR),
        .PULSE_LIMIT      (PULSE_LIMIT)
    ) eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (eng_clear),
        .run       (state_q == ST_ERASE),
        .force_over(force_limit),
        .mask      (mask_q),
        .done      (eng_done),
        .over      (eng_over)
    );

    sew_status_gen sts_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state_q),
        .status_rd(status_rd),
        .status   (status)
    );

    // Drive the block outputs from registered state.
    always_comb begin
        sector_mask  = mask_q;
        erase_active = (state_q == ST_ERASE);
    end

endmodule

// File: rtl/sew_checker.sv
// Module: protocol checker for sector_erase_ctl, attached by bind.
// Observes only the top-level ports. Assumes reset is held low from time zero.
module sew_checker #(
    parameter int NUM_SECTORS = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_valid,
    input logic [2:0]             cmd_code,
    input logic                   status_rd,
    input logic [7:0]             status,
    input logic [NUM_SECTORS-1:0] sector_mask,
    input logic                   erase_active
);
    import sew_pkg::*;

    AST_ACTIVE_TIMER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        erase_active |-> (status[3] && !status[7])); // R2

    AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[7] && !status[3] && cmd_valid && (cmd_code == CMD_SECTOR_ERASE))
        |=> (!status[3] && !erase_active)); // R3

    AST_CHIP_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !status[3] && cmd_valid && (cmd_code == CMD_CHIP_ERASE))
        |=> (erase_active && (sector_mask == '1))); // R4

    AST_ERASE_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_active && cmd_valid && (cmd_code != CMD_SUSPEND))
        |=> ((sector_mask == $past(sector_mask)) || (sector_mask == '0))); // R5

    AST_IDLE_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !status[3]) |-> (sector_mask == '0)); // R6

    AST_FAIL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        status[5] |-> (!erase_active && status[3] && !status[7])); // R7

    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !(cmd_valid && (cmd_code == CMD_RESET))) |=> status[5]); // R8

    AST_TOGGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[7] && status_rd) |=> (status[6] != $past(status[6]))); // R9

    AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !cmd_valid) |=> $stable(status[6])); // R9

endmodule

bind sector_erase_ctl sew_checker #(
    .NUM_SECTORS(NUM_SECTORS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .status_rd   (status_rd),
    .status      (status),
    .sector_mask (sector_mask),
    .erase_active(erase_active)
);

// File: tb/sector_erase_ctl_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard-style test of sector_erase_ctl with a short window.
// The driver issues commands at falling edges and queues expected outputs;
// the monitor pops and compares them in the same time slot.
module sector_erase_ctl_tb_top;

    localparam int NS    = 8;
    localparam int SW    = 3;
    localparam int WIN   = 50;  // CLK_MHZ=1 * WINDOW_US=50
    localparam int PPS   = 4;
    localparam int LIMIT = 20;

    typedef struct {
        string      tag;
        logic [7:0] st;
        logic [7:0] mask;
        logic       act;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_code = 3'd0;
    logic [SW-1:0] cmd_sector = '0;
    logic          status_rd = 1'b0;
    logic          force_limit = 1'b0;
    logic [7:0]    status;
    logic [NS-1:0] sector_mask;
    logic          erase_active;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];
    event chk_ev;

    always #2 clk = ~clk;

    sector_erase_ctl #(
        .CLK_MHZ          (1),
        .WINDOW_US        (WIN),
        .NUM_SECTORS      (NS),
        .PULSES_PER_SECTOR(PPS),
        .PULSE_LIMIT      (LIMIT)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .cmd_sector  (cmd_sector),
        .status_rd   (status_rd),
        .force_limit (force_limit),
        .status      (status),
        .sector_mask (sector_mask),
        .erase_active(erase_active)
    );

    // Queue one expected observation and wake the monitor.
    task automatic expect_now(input string tag, input logic [7:0] st,
                              input logic [7:0] mask, input logic act);
        exp_t e;
        e.tag = tag; e.st = st; e.mask = mask; e.act = act;
        exp_q.push_back(e);
        -> chk_ev;
    endtask

    // Drive one command for one cycle; called at a falling edge.
    task automatic issue(input logic [2:0] code, input int sec);
        cmd_valid  = 1'b1;
        cmd_code   = code;
        cmd_sector = SW'(sec);
        @(negedge clk);
        cmd_valid  = 1'b0;
        cmd_code   = 3'd0;
    endtask

    // Pulse one status read; called at a falling edge.
    task automatic rd_status();
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare every queued expectation against the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (status !== e.st || sector_mask !== e.mask || erase_active !== e.act) begin
                    n_fail++;
                    $display("FAIL %s: status=%h mask=%h active=%b, expected status=%h mask=%h active=%b",
                             e.tag, status, sector_mask, erase_active, e.st, e.mask, e.act);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Driver: scenario sequence with expected values from the requirements.
    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R1 reset state", 8'h80, 8'h00, 1'b0);

        // Window, restart, completion, toggle (R2 R3 R6 R9)
        issue(3'd1, 2);
        expect_now("R2 window open", 8'h00, 8'h04, 1'b0);
        rd_status();
        expect_now("R9 toggle after read in window", 8'h40, 8'h04, 1'b0);
        wait_cyc(20);
        issue(3'd1, 5);
        expect_now("R3 sector added", 8'h40, 8'h24, 1'b0);
        wait_cyc(WIN - 1);
        expect_now("R3 window restarted, still open", 8'h40, 8'h24, 1'b0);
        wait_cyc(1);
        expect_now("R2 window expired, erase running", 8'h48, 8'h24, 1'b1);
        wait_cyc(2 * PPS - 1);
        expect_now("R6 erase still running", 8'h48, 8'h24, 1'b1);
        wait_cyc(1);
        expect_now("R6 erase complete, idle", 8'hC0, 8'h00, 1'b0);
        rd_status();
        expect_now("R9 no toggle when idle", 8'hC0, 8'h00, 1'b0);

        // Chip erase over the limit, failure latch (R4 R7 R8 R9)
        issue(3'd2, 0);
        expect_now("R4 chip erase starts at once", 8'h48, 8'hFF, 1'b1);
        wait_cyc(LIMIT);
        expect_now("R7 limit not yet passed", 8'h48, 8'hFF, 1'b1);
        wait_cyc(1);
        expect_now("R7 limit passed, failure", 8'h68, 8'hFF, 1'b0);
        issue(3'd1, 1);
        issue(3'd2, 0);
        issue(3'd3, 0);
        issue(3'd4, 0);
        expect_now("R8 commands ignored after failure", 8'h68, 8'hFF, 1'b0);
        rd_status();
        expect_now("R9 toggle while failed", 8'h28, 8'hFF, 1'b0);
        issue(3'd5, 0);
        expect_now("R8 reset clears failure", 8'h00 | 8'h80, 8'h00, 1'b0);

        // Lockout, suspend/resume, batch equal to limit (R5 R7)
        for (int s = 0; s < 5; s++) begin
            issue(3'd1, s);
        end
        expect_now("R3 five sectors collected", 8'h00, 8'h1F, 1'b0);
        wait_cyc(WIN - 1);
        expect_now("R2 window still open at last cycle", 8'h00, 8'h1F, 1'b0);
        wait_cyc(1);
        expect_now("R2 erase begins", 8'h08, 8'h1F, 1'b1);
        issue(3'd5, 0);
        issue(3'd1, 7);
        issue(3'd2, 0);
        expect_now("R5 commands ignored during erase", 8'h08, 8'h1F, 1'b1);
        issue(3'd3, 0);
        expect_now("R5 suspended", 8'h88, 8'h1F, 1'b0);
        rd_status();
        expect_now("R9 no toggle while suspended", 8'h88, 8'h1F, 1'b0);
        wait_cyc(10);
        expect_now("R5 suspend holds", 8'h88, 8'h1F, 1'b0);
        issue(3'd4, 0);
        expect_now("R5 resumed", 8'h08, 8'h1F, 1'b1);
        wait_cyc(15);
        expect_now("R7 pulses kept across suspend", 8'h08, 8'h1F, 1'b1);
        wait_cyc(1);
        expect_now("R7 batch equal to limit completes", 8'h80, 8'h00, 1'b0);

        // Abandon in window, forced failure (R10 R7 R8)
        issue(3'd1, 3);
        expect_now("R2 window for sector 3", 8'h00, 8'h08, 1'b0);
        issue(3'd3, 0);
        expect_now("R10 suspend ignored in window", 8'h00, 8'h08, 1'b0);
        issue(3'd0, 0);
        expect_now("R10 other command abandons batch", 8'h80, 8'h00, 1'b0);
        issue(3'd1, 6);
        wait_cyc(WIN);
        expect_now("R2 erase for sector 6", 8'h08, 8'h40, 1'b1);
        force_limit = 1'b1;
        @(negedge clk);
        force_limit = 1'b0;
        expect_now("R7 forced limit failure", 8'h28, 8'h40, 1'b0);
        issue(3'd5, 0);
        expect_now("R8 reset after forced failure", 8'h80, 8'h00, 1'b0);

        @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule